// File: doc/BRIEF.md
# Turbo Interleaver Address Generator

This block produces the read addresses that put a block of K symbols into interleaved order for a turbo encoder or decoder. After a start pulse it sends every index j from 0 to K−1 through a permutation and emits one address per clock. It marks each address as valid and flags the final one. There are three permutations. The first is a plain circular one, P·j mod K. The second is a perturbed circular one, which adds a short periodic list of offsets to break up the regular pattern. The third is a quadratic polynomial of j. All arithmetic is done by running sums reduced against K, so the datapath holds adders and comparators but no multiplier.

Before a linear-mode run, the block checks that the step P shares no factor with K. It does this with an iterative subtractive greatest-common-divisor unit, because otherwise the sequence would not be a permutation. It also rejects configurations that are out of range. When either check fails, it raises an error flag and emits no address. All configuration inputs must stay stable from the start pulse until the last address or the error flag.

Top module: `ilv_addr_gen`

## Requirements
- R1: With mode_i = 0 (regular), the addresses are (P·j) mod K for j = 0..K−1, in order, on K consecutive clocks, with valid_o high and no gap.
- R2: With mode_i = 1 (shifted), address j is ((P·j) mod K + S[j mod Q]) mod K. Q = 2^qlog_i, and entry S[i] occupies shifts_i[12·i +: 12]. Each entry must be below K.
- R3: With mode_i = 2 (quadratic), address j is (f1·j + f2·j²) mod K.
- R4: In modes 0 and 1, if gcd(P, K) ≠ 1, err_o rises when the divisor check completes, and no valid address is ever emitted.
- R5: A range error raises err_o right after the clock edge that samples start_i, and no address is emitted. A range error is any of: K < 2, K > 4096, mode_i = 3, P = 0 or P ≥ K in modes 0 and 1, f1 ≥ K or f2 ≥ K in mode 2, or qlog_i > 4 in mode 1.
- R6: done_o is high together with the address for j = K−1 and at no other time. valid_o is low on the following clock.
- R7: In mode 2 the first address is on the outputs after the second rising edge, counting the edge that samples start_i.
- R8: start_i is ignored while a check or a run is in progress. The running sequence continues unchanged.
- R9: After reset, valid_o, done_o and err_o are low. A start accepted while idle clears err_o.
- R10: Every emitted address is below K.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, sampled while idle |
| mode_i | input | 2 | 0 regular, 1 shifted, 2 quadratic |
| k_i | input | 13 | Block length K |
| p_i | input | 12 | Circular step P |
| f1_i | input | 12 | Linear polynomial coefficient |
| f2_i | input | 12 | Quadratic polynomial coefficient |
| qlog_i | input | 3 | log2 of the shift list length |
| shifts_i | input | 192 | Sixteen 12-bit shift entries |
| addr_o | output | 12 | Interleaved address |
| valid_o | output | 1 | addr_o holds a valid address |
| done_o | output | 1 | Marks the last address |
| err_o | output | 1 | Configuration rejected |

## Verification
Some properties are checked on every cycle:
- the output stream is contiguous until done_o;
- done_o only accompanies a valid address and is followed by an idle cycle;
- no address reaches K;
- valid_o never coincides with err_o;
- the divisor unit's operands never grow.

Other properties can only be shown by the bench's sweeps:
- whether each sequence holds the right values, in the right order, and forms a bijection on 0..K−1;
- the quadratic start latency;
- detection of shared factors;
- immunity to a start pulse in the middle of a run.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  typedef enum logic [1:0] {
    MODE_REG = 2'd0,
    MODE_SHF = 2'd1,
    MODE_QPP = 2'd2,
    MODE_BAD = 2'd3
  } ilv_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_GEN   = 2'd2
  } ilv_state_e;
endpackage

// File: rtl/ilv_modadd.sv
module ilv_modadd #(
  parameter int W = 13
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] k_i,
  output logic [W-1:0] s_o
);
  // operands are below k_i, so one conditional subtract suffices
  logic [W:0] sum;
  always_comb begin
    sum = {1'b0, a_i} + {1'b0, b_i};
    if (sum >= {1'b0, k_i}) s_o = W'(sum - {1'b0, k_i});
    else                     s_o = sum[W-1:0];
  end
endmodule

// File: rtl/ilv_coprime.sv
module ilv_coprime #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         done_o,
  output logic         ok_o
);
  logic [W-1:0] ga_q, ga_n, gb_q, gb_n;
  logic         run_q, run_n, done_q, done_n, ok_q, ok_n;

  always_comb begin
    ga_n   = ga_q;
    gb_n   = gb_q;
    run_n  = run_q;
    ok_n   = ok_q;
    done_n = 1'b0;
    if (load_i) begin
      ga_n  = a_i;
      gb_n  = b_i;
      run_n = 1'b1;
      ok_n  = 1'b0;
    end else if (run_q) begin
      if (gb_q == '0) begin
        run_n  = 1'b0;
        done_n = 1'b1;
        ok_n   = (ga_q == W'(1));
      end else if (ga_q >= gb_q) begin
        ga_n = ga_q - gb_q;
      end else begin
        ga_n = gb_q;
        gb_n = ga_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ga_q   <= '0;
      gb_q   <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
      ok_q   <= 1'b0;
    end else begin
      ga_q   <= ga_n;
      gb_q   <= gb_n;
      run_q  <= run_n;
      done_q <= done_n;
      ok_q   <= ok_n;
    end
  end

  assign done_o = done_q;
  assign ok_o   = ok_q;

  // R4
  gcd_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q)) |->
      ({1'b0, ga_q} + {1'b0, gb_q}) <= $past({1'b0, ga_q} + {1'b0, gb_q}));
endmodule

// File: rtl/ilv_shift_sel.sv
module ilv_shift_sel #(
  parameter int AW  = 12,
  parameter int NSH = 16,
  localparam int SIW = $clog2(NSH),
  localparam int QLW = $clog2(SIW + 1)
) (
  input  logic [SIW-1:0]    idx_i,
  input  logic [QLW-1:0]    qlog_i,
  input  logic [NSH*AW-1:0] tbl_i,
  output logic [AW-1:0]     val_o
);
  logic [SIW-1:0] mask;
  logic [AW-1:0]  ent [NSH];

  for (genvar b = 0; b < SIW; b++) begin : g_mask
    assign mask[b] = (qlog_i > QLW'(b));
  end

  for (genvar i = 0; i < NSH; i++) begin : g_ent
    assign ent[i] = tbl_i[i*AW +: AW];
  end

  assign val_o = ent[idx_i & mask];
endmodule

// File: rtl/ilv_addr_gen.sv
module ilv_addr_gen
  import ilv_pkg::*;
#(
  parameter int KMAX = 4096,
  parameter int NSH  = 16,
  localparam int KW  = $clog2(KMAX + 1),
  localparam int AW  = $clog2(KMAX),
  localparam int SIW = $clog2(NSH),
  localparam int QLW = $clog2(SIW + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic [KW-1:0]     k_i,
  input  logic [AW-1:0]     p_i,
  input  logic [AW-1:0]     f1_i,
  input  logic [AW-1:0]     f2_i,
  input  logic [QLW-1:0]    qlog_i,
  input  logic [NSH*AW-1:0] shifts_i,
  output logic [AW-1:0]     addr_o,
  output logic              valid_o,
  output logic              done_o,
  output logic              err_o
);
  ilv_state_e  st_q, st_n;
  ilv_mode_e   mode_w;
  logic [KW-1:0] j_q, j_n, lin_q, lin_n, qv_q, qv_n, qd_q, qd_n, s2_q, s2_n;
  logic [AW-1:0] addr_q, addr_n;
  logic          valid_q, valid_n, done_q, done_n, err_q, err_n;
  logic [KW-1:0] px, f1x, f2x, shx;
  logic [KW-1:0] lin_adv, lin_sh, qv_adv, qd_adv, d0, s2;
  logic [AW-1:0] shv;
  logic          bad_cfg, last, cp_load, cp_done, cp_ok;

  assign mode_w = ilv_mode_e'(mode_i);
  assign px  = KW'(p_i);
  assign f1x = KW'(f1_i);
  assign f2x = KW'(f2_i);
  assign shx = KW'(shv);

  ilv_modadd #(.W(KW)) u_lin_adv (.a_i(lin_q), .b_i(px),  .k_i(k_i), .s_o(lin_adv));
  ilv_modadd #(.W(KW)) u_lin_sh  (.a_i(lin_q), .b_i(shx), .k_i(k_i), .s_o(lin_sh));
  ilv_modadd #(.W(KW)) u_qv_adv  (.a_i(qv_q),  .b_i(qd_q), .k_i(k_i), .s_o(qv_adv));
  ilv_modadd #(.W(KW)) u_qd_adv  (.a_i(qd_q),  .b_i(s2_q), .k_i(k_i), .s_o(qd_adv));
  ilv_modadd #(.W(KW)) u_d0      (.a_i(f1x),   .b_i(f2x),  .k_i(k_i), .s_o(d0));
  ilv_modadd #(.W(KW)) u_s2      (.a_i(f2x),   .b_i(f2x),  .k_i(k_i), .s_o(s2));

  ilv_shift_sel #(.AW(AW), .NSH(NSH)) u_shift_sel (
    .idx_i (j_q[SIW-1:0]),
    .qlog_i(qlog_i),
    .tbl_i (shifts_i),
    .val_o (shv)
  );

  ilv_coprime #(.W(KW)) u_coprime (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(cp_load),
    .a_i   (k_i),
    .b_i   (px),
    .done_o(cp_done),
    .ok_o  (cp_ok)
  );

  always_comb begin
    bad_cfg = (k_i < KW'(2)) || (k_i > KW'(KMAX)) || (mode_w == MODE_BAD);
    if (mode_w == MODE_QPP) bad_cfg = bad_cfg || (f1x >= k_i) || (f2x >= k_i);
    else                    bad_cfg = bad_cfg || (px == '0) || (px >= k_i);
    if (mode_w == MODE_SHF) bad_cfg = bad_cfg || (qlog_i > QLW'(SIW));
  end

  assign last = (j_q == k_i - KW'(1));

  always_comb begin
    st_n    = st_q;
    j_n     = j_q;
    lin_n   = lin_q;
    qv_n    = qv_q;
    qd_n    = qd_q;
    s2_n    = s2_q;
    addr_n  = addr_q;
    err_n   = err_q;
    valid_n = 1'b0;
    done_n  = 1'b0;
    cp_load = 1'b0;
    case (st_q)
      ST_IDLE: if (start_i) begin
        err_n = 1'b0;
        if (bad_cfg) begin
          err_n = 1'b1;
        end else begin
          st_n    = (mode_w == MODE_QPP) ? ST_GEN : ST_CHECK;
          cp_load = (mode_w != MODE_QPP);
          j_n     = '0;
          lin_n   = '0;
          qv_n    = '0;
          qd_n    = d0;
          s2_n    = s2;
        end
      end
      ST_CHECK: if (cp_done) begin
        if (cp_ok) begin
          st_n = ST_GEN;
        end else begin
          err_n = 1'b1;
          st_n  = ST_IDLE;
        end
      end
      ST_GEN: begin
        valid_n = 1'b1;
        done_n  = last;
        case (mode_w)
          MODE_SHF: addr_n = AW'(lin_sh);
          MODE_QPP: addr_n = AW'(qv_q);
          default:  addr_n = AW'(lin_q);
        endcase
        j_n   = j_q + KW'(1);
        lin_n = lin_adv;
        qv_n  = qv_adv;
        qd_n  = qd_adv;
        if (last) st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      j_q     <= '0;
      lin_q   <= '0;
      qv_q    <= '0;
      qd_q    <= '0;
      s2_q    <= '0;
      addr_q  <= '0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_n;
      j_q     <= j_n;
      lin_q   <= lin_n;
      qv_q    <= qv_n;
      qd_q    <= qd_n;
      s2_q    <= s2_n;
      addr_q  <= addr_n;
      valid_q <= valid_n;
      done_q  <= done_n;
      err_q   <= err_n;
    end
  end

  assign addr_o  = addr_q;
  assign valid_o = valid_q;
  assign done_o  = done_q;
  assign err_o   = err_q;

  // R1
  valid_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !done_o) |=> valid_o);
  // R6
  done_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> valid_o);
  // R6
  done_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !valid_o);
  // R10
  addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (KW'(addr_o) < k_i));
  // R4
  err_novalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !valid_o);
endmodule

// File: tb/ilv_addr_gen_bench.sv
module ilv_addr_gen_bench;
  localparam int AW = 12;
  localparam int NSH = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic [1:0] mode;
  logic [12:0] k;
  logic [11:0] p, f1, f2;
  logic [2:0] qlog;
  logic [NSH*AW-1:0] shifts;
  logic [11:0] sh [NSH];
  logic [11:0] addr;
  logic valid, done, err;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  always_comb
    for (int i = 0; i < NSH; i++) shifts[i*AW +: AW] = sh[i];

  ilv_addr_gen u_ilv_addr_gen (
    .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode), .k_i(k),
    .p_i(p), .f1_i(f1), .f2_i(f2), .qlog_i(qlog), .shifts_i(shifts),
    .addr_o(addr), .valid_o(valid), .done_o(done), .err_o(err)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 199000) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: act=%0d exp=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int gcd(input int a, input int b);
    while (b != 0) begin
      int t = a % b;
      a = b;
      b = t;
    end
    return a;
  endfunction

  task automatic run_case(input int md, input int kk, input int pp, input int ff1,
                          input int ff2, input int ql, input bit poke);
    bit rng, exp_err, gap, dbad, mism;
    bit seen [4096];
    int got, waited, first_it, dup, bad_a, bad_e, qn;
    string req;
    req = (md == 2) ? "R3" : (md == 1) ? "R2" : "R1";
    rng = (kk < 2) || (kk > 4096) || (md == 3) ||
          (md != 2 && (pp == 0 || pp >= kk)) ||
          (md == 2 && (ff1 >= kk || ff2 >= kk)) || (md == 1 && ql > 4);
    exp_err = rng || (md != 2 && gcd(pp, kk) != 1);
    qn = 1 << ql;
    for (int i = 0; i < 4096; i++) seen[i] = 1'b0;
    mode = 2'(md); k = 13'(kk); p = 12'(pp); f1 = 12'(ff1); f2 = 12'(ff2); qlog = 3'(ql);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (rng) chk(err == 1'b1, "R5 immediate", err, 1);
    got = 0; waited = 0; first_it = -1; dup = 0; gap = 0; dbad = 0; mism = 0;
    bad_a = 0; bad_e = 0;
    while (got < kk && waited < 4 * kk + 64) begin
      start = (poke && got == kk / 2) ? 1'b1 : 1'b0;
      if (valid) begin
        longint e;
        if (md == 2) e = (longint'(ff1) * got + longint'(ff2) * got * got) % kk;
        else begin
          e = (longint'(pp) * got) % kk;
          if (md == 1) e = (e + sh[got % qn]) % kk;
        end
        if (first_it < 0) first_it = waited;
        if (longint'(addr) != e && !mism) begin
          mism = 1; bad_a = int'(addr); bad_e = int'(e);
        end
        if (addr < 4096) begin
          if (seen[addr]) dup++;
          seen[addr] = 1'b1;
        end
        if (done != (got == kk - 1)) dbad = 1;
        got++;
      end else if (got > 0) gap = 1;
      if (err) break;
      waited++;
      @(negedge clk);
    end
    start = 1'b0;
    if (exp_err) begin
      chk(err == 1'b1, rng ? "R5" : "R4", err, 1);
      chk(got == 0, rng ? "R5 no output" : "R4 no output", got, 0);
    end else begin
      chk(!mism, req, bad_a, bad_e);
      chk(dup == 0 && got == kk, {req, " bijection"}, dup, 0);
      chk(!gap, {req, " contiguous"}, gap, 0);
      chk(!dbad, "R6 done mark", dbad, 0);
      chk(valid == 1'b0, "R6 valid drop", valid, 0);
      chk(err == 1'b0, "R9 err clear", err, 0);
      if (md == 2) chk(first_it == 1, "R7 latency", first_it, 1);
      if (poke) chk(!mism && got == kk, "R8 start ignored", got, kk);
    end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    start = 1'b0; mode = '0; k = 13'd64; p = 12'd5; f1 = '0; f2 = '0; qlog = '0;
    for (int i = 0; i < NSH; i++) sh[i] = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(valid == 0 && done == 0 && err == 0, "R9 reset", {valid, done, err}, 0);

    run_case(0, 64, 5, 0, 0, 0, 0);
    run_case(0, 97, 13, 0, 0, 0, 0);
    run_case(0, 4096, 4095, 0, 0, 0, 0);
    run_case(0, 64, 5, 0, 0, 0, 1);

    sh[0] = 12'd0; sh[1] = 12'd8; sh[2] = 12'd20; sh[3] = 12'd44;
    run_case(1, 64, 5, 0, 0, 2, 0);
    for (int i = 0; i < NSH; i++) sh[i] = 12'(16 * ((3 * i) % 16));
    run_case(1, 256, 37, 0, 0, 4, 0);
    sh[0] = 12'd10;
    run_case(1, 50, 7, 0, 0, 0, 0);

    run_case(2, 64, 0, 3, 8, 0, 0);
    run_case(2, 256, 0, 15, 32, 0, 1);

    run_case(0, 64, 8, 0, 0, 0, 0);
    run_case(0, 64, 0, 0, 0, 0, 0);
    run_case(0, 1, 1, 0, 0, 0, 0);
    run_case(2, 64, 0, 3, 70, 0, 0);
    run_case(3, 64, 5, 0, 0, 0, 0);
    run_case(1, 64, 5, 0, 0, 5, 0);
    run_case(0, 16, 3, 0, 0, 0, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule